// File: doc/BRIEF.md
# ALU-Shifter Function Unit

This block is the combinational function unit of a register-based datapath. It takes two operands, A and B, and a 4-bit function select. It returns a result F together with four status bits: overflow (V), carry (C), negative (N) and zero (Z). Inside it there is an adder-based arithmetic circuit, a bitwise logic circuit, a one-position shifter that works on B, and a final result selector.

The four select bits are shared among the sub-units by fixed wiring:
- The arithmetic circuit uses bits [2:1] to choose the adder's second operand and bit [0] as its carry-in.
- The logic circuit and the shifter each decode bits [1:0].
- Bit [3] separates arithmetic from the other kinds of operation.
- Bits [3:2] both set to 1 select the shifter output over the ALU output.

The two bits that fill the vacated end of a shift come in on ports. The width is a parameter, and the block holds no state.

Top module: `fu_core`

## Requirements
- R1: For fs[3]=0 the result is A + Y + fs[0] modulo 2^W. Y is selected by fs[2:1]: 00 gives all zeros, 01 gives B, 10 gives ~B, 11 gives all ones. Codes 0000..0111 therefore give A, A+1, A+B, A+B+1, A+~B, A-B, A-1 and A.
- R2: Codes 1000, 1001, 1010 and 1011 give A&B, A|B, A^B and ~A.
- R3: Codes 1100 and 1111 give B unchanged.
- R4: Code 1101 gives B shifted right by one position, with fill_r entering the MSB.
- R5: Code 1110 gives B shifted left by one position, with fill_l entering the LSB.
- R6: For fs[3]=0, c_flag is the adder's carry out of bit W-1. v_flag is 1 exactly when the two's-complement sum of A, Y and the carry-in lies outside the signed W-bit range.
- R7: For fs[3]=1, c_flag and v_flag are both 0.
- R8: n_flag equals bit W-1 of f_out, and z_flag is 1 exactly when f_out is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | W | Operand A |
| b_in | input | W | Operand B; also the shifter's input |
| fs | input | 4 | Function select |
| fill_r | input | 1 | Bit that enters the MSB on a right shift |
| fill_l | input | 1 | Bit that enters the LSB on a left shift |
| f_out | output | W | Selected result F |
| v_flag | output | 1 | Signed overflow |
| c_flag | output | 1 | Carry out |
| n_flag | output | 1 | Negative (MSB of F) |
| z_flag | output | 1 | Zero detect on F |

## Verification
The bench builds the unit with W=8. At that width, the boundary operands 0x7F, 0x80 and 0xFF can be worked out by hand, so the vector table can pin down carry, overflow and zero cases exactly for every function code. W=8 also keeps it cheap to sweep all sixteen codes, both fill values and a set of edge operands against a model in the bench built from integer arithmetic, which covers the unused shifter code and the fill bits on each shift direction.

// File: rtl/fu_pkg.sv
package fu_pkg;

    typedef enum logic [3:0] {
        FS_PASS_A   = 4'b0000,
        FS_INC      = 4'b0001,
        FS_ADD      = 4'b0010,
        FS_ADD_C    = 4'b0011,
        FS_ADD_NB   = 4'b0100,
        FS_SUB      = 4'b0101,
        FS_DEC      = 4'b0110,
        FS_PASS_A2  = 4'b0111,
        FS_AND      = 4'b1000,
        FS_OR       = 4'b1001,
        FS_XOR      = 4'b1010,
        FS_NOT_A    = 4'b1011,
        FS_PASS_B   = 4'b1100,
        FS_SHR      = 4'b1101,
        FS_SHL      = 4'b1110,
        FS_SPARE    = 4'b1111
    } fu_op_e;

    typedef struct packed {
        logic v;
        logic c;
        logic n;
        logic z;
    } fu_flags_t;

    // true when the shifter output is the one selected
    function automatic logic fu_takes_shift(input logic [3:0] code);
        return code[3] & code[2];
    endfunction

    // true when the arithmetic circuit drives the result
    function automatic logic fu_is_arith(input logic [3:0] code);
        return ~code[3];
    endfunction

endpackage

// File: rtl/fu_arith.sv
module fu_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   ysel,
    input  logic         cin,
    output logic [W-1:0] g,
    output logic         cout,
    output logic         ovf
);
    localparam int SW = W + 1;

    logic [W-1:0]  y;
    logic [SW-1:0] sum;

    always_comb begin
        unique case (ysel)
            2'b00:   y = '0;
            2'b01:   y = b;
            2'b10:   y = ~b;
            default: y = '1;
        endcase
        sum  = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, cin};
        g    = sum[W-1:0];
        cout = sum[W];
        ovf  = (a[W-1] == y[W-1]) && (g[W-1] != a[W-1]);
    end

    always_comb begin
        if (ysel == 2'b10 && cin)
            assert_sub_result_R1: assert (g == a - b)
                else $error("subtract result mismatch");
        if (ysel == 2'b01 && !cin && ovf)
            assert_add_ovf_signs_R6: assert (a[W-1] == b[W-1])
                else $error("overflow with unlike operand signs");
    end

endmodule

// File: rtl/fu_logic.sv
module fu_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   lsel,
    output logic [W-1:0] r
);
    always_comb begin
        unique case (lsel)
            2'b00:   r = a & b;
            2'b01:   r = a | b;
            2'b10:   r = a ^ b;
            default: r = ~a;
        endcase
    end
endmodule

// File: rtl/fu_shift.sv
module fu_shift #(
    parameter int W = 8
) (
    input  logic [W-1:0] b,
    input  logic [1:0]   hsel,
    input  logic         fill_r,
    input  logic         fill_l,
    output logic [W-1:0] h
);
    logic [W-1:0] right_v;
    logic [W-1:0] left_v;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            if (i == W - 1) begin : g_top
                assign right_v[i] = fill_r;
            end else begin : g_rmid
                assign right_v[i] = b[i+1];
            end
            if (i == 0) begin : g_bot
                assign left_v[i] = fill_l;
            end else begin : g_lmid
                assign left_v[i] = b[i-1];
            end
        end
    endgenerate

    always_comb begin
        unique case (hsel)
            2'b01:   h = right_v;
            2'b10:   h = left_v;
            default: h = b;
        endcase
    end
endmodule

// File: rtl/fu_core.sv
module fu_core
    import fu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [3:0]   fs,
    input  logic         fill_r,
    input  logic         fill_l,
    output logic [W-1:0] f_out,
    output logic         v_flag,
    output logic         c_flag,
    output logic         n_flag,
    output logic         z_flag
);
    localparam int MSB = W - 1;

    logic [W-1:0] g_arith;
    logic [W-1:0] g_logic;
    logic [W-1:0] h_shift;
    logic         a_cout;
    logic         a_ovf;
    logic [W-1:0] alu_g;
    fu_flags_t    st;

    fu_arith #(.W(W)) u_arith (
        .a(a_in), .b(b_in), .ysel(fs[2:1]), .cin(fs[0]),
        .g(g_arith), .cout(a_cout), .ovf(a_ovf)
    );

    fu_logic #(.W(W)) u_logic (
        .a(a_in), .b(b_in), .lsel(fs[1:0]), .r(g_logic)
    );

    fu_shift #(.W(W)) u_shift (
        .b(b_in), .hsel(fs[1:0]), .fill_r(fill_r), .fill_l(fill_l), .h(h_shift)
    );

    always_comb begin
        alu_g = fu_is_arith(fs) ? g_arith : g_logic;
        f_out = fu_takes_shift(fs) ? h_shift : alu_g;
        st.v  = fu_is_arith(fs) & a_ovf;
        st.c  = fu_is_arith(fs) & a_cout;
        st.n  = f_out[MSB];
        st.z  = ~|f_out;
    end

    assign v_flag = st.v;
    assign c_flag = st.c;
    assign n_flag = st.n;
    assign z_flag = st.z;

    always_comb begin
        if (fs[3])
            assert_no_carry_ovf_R7: assert (!c_flag && !v_flag)
                else $error("flags set outside arithmetic");
        if (fs == FS_PASS_B)
            assert_pass_b_R3: assert (f_out == b_in)
                else $error("pass-B mismatch");
        if (fs == FS_SHR)
            assert_rfill_R4: assert (f_out[MSB] == fill_r && f_out[MSB-1:0] == b_in[MSB:1])
                else $error("right shift mismatch");
        if (fs == FS_SHL)
            assert_lfill_R5: assert (f_out[0] == fill_l && f_out[MSB:1] == b_in[MSB-1:0])
                else $error("left shift mismatch");
        if (z_flag)
            assert_zero_not_neg_R8: assert (!n_flag)
                else $error("zero result flagged negative");
    end

endmodule

// File: tb/sim_fu_core.sv
module sim_fu_core;
    localparam int W = 8;
    localparam time CLK_PERIOD = 10ns;
    localparam int NV = 20;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] a_in, b_in, f_out;
    logic [3:0] fs;
    logic fill_r, fill_l, v_flag, c_flag, n_flag, z_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fu_core #(.W(W)) u0 (
        .a_in(a_in), .b_in(b_in), .fs(fs), .fill_r(fill_r), .fill_l(fill_l),
        .f_out(f_out), .v_flag(v_flag), .c_flag(c_flag), .n_flag(n_flag), .z_flag(z_flag)
    );

    // {fs, a, b, fill_r, fill_l, expected F, expected {v,c,n,z}}
    localparam logic [33:0] VEC [NV] = '{
        {4'b0000, 8'h5A, 8'h00, 1'b0, 1'b0, 8'h5A, 4'b0000},
        {4'b0001, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 4'b0101},
        {4'b0010, 8'h7F, 8'h01, 1'b0, 1'b0, 8'h80, 4'b1010},
        {4'b0011, 8'h10, 8'h20, 1'b0, 1'b0, 8'h31, 4'b0000},
        {4'b0100, 8'h10, 8'h0F, 1'b0, 1'b0, 8'h00, 4'b0101},
        {4'b0101, 8'h05, 8'h07, 1'b0, 1'b0, 8'hFE, 4'b0010},
        {4'b0101, 8'h80, 8'h01, 1'b0, 1'b0, 8'h7F, 4'b1100},
        {4'b0110, 8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 4'b0010},
        {4'b0111, 8'h3C, 8'h00, 1'b0, 1'b0, 8'h3C, 4'b0100},
        {4'b1000, 8'hCC, 8'hAA, 1'b0, 1'b0, 8'h88, 4'b0010},
        {4'b1001, 8'hCC, 8'hAA, 1'b0, 1'b0, 8'hEE, 4'b0010},
        {4'b1010, 8'hCC, 8'hAA, 1'b0, 1'b0, 8'h66, 4'b0000},
        {4'b1011, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 4'b0001},
        {4'b1100, 8'h00, 8'h81, 1'b0, 1'b0, 8'h81, 4'b0010},
        {4'b1101, 8'h00, 8'h81, 1'b0, 1'b0, 8'h40, 4'b0000},
        {4'b1101, 8'h00, 8'h81, 1'b1, 1'b0, 8'hC0, 4'b0010},
        {4'b1110, 8'h00, 8'h81, 1'b0, 1'b0, 8'h02, 4'b0000},
        {4'b1110, 8'h00, 8'h81, 1'b0, 1'b1, 8'h03, 4'b0000},
        {4'b1111, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 4'b0001},
        {4'b0010, 8'h80, 8'h80, 1'b0, 1'b0, 8'h00, 4'b1101}
    };

    function automatic string req_of(input logic [3:0] code);
        if (!code[3]) return "R1/R6";
        if (!code[2]) return "R2/R7";
        if (code == 4'b1101) return "R4/R7";
        if (code == 4'b1110) return "R5/R7";
        return "R3/R7";
    endfunction

    task automatic compare(input string req, input logic [W-1:0] ef, input logic [3:0] eflg);
        logic [3:0] got;
        got = {v_flag, c_flag, n_flag, z_flag};
        checks++;
        if (f_out !== ef || got !== eflg) begin
            fails++;
            $display("FAIL %s fs=%b a=%h b=%h: got F=%h vcnz=%b, expected F=%h vcnz=%b",
                     req, fs, a_in, b_in, f_out, got, ef, eflg);
        end
    endtask

    task automatic apply(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic ir, input logic il);
        @(posedge clk);
        fs = c; a_in = a; b_in = b; fill_r = ir; fill_l = il;
        @(negedge clk);
    endtask

    // Independent integer model
    task automatic model(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic ir, input logic il,
                         output logic [W-1:0] ef, output logic [3:0] eflg);
        int ua, uy, us, sa, sy, ss, ci;
        logic v, cy;
        v = 1'b0; cy = 1'b0; ef = '0;
        if (!c[3]) begin
            ci = int'(c[0]);
            case (c[2:1])
                2'b00: uy = 0;
                2'b01: uy = int'(b);
                2'b10: uy = 255 - int'(b);
                default: uy = 255;
            endcase
            ua = int'(a);
            us = ua + uy + ci;
            ef = us[W-1:0];
            cy = (us > 255);
            sa = (ua > 127) ? ua - 256 : ua;
            sy = (uy > 127) ? uy - 256 : uy;
            ss = sa + sy + ci;
            v  = (ss > 127) || (ss < -128);
        end else if (!c[2]) begin
            case (c[1:0])
                2'b00: ef = a & b;
                2'b01: ef = a | b;
                2'b10: ef = a ^ b;
                default: ef = ~a;
            endcase
        end else begin
            case (c[1:0])
                2'b01: ef = {ir, b[W-1:1]};
                2'b10: ef = {b[W-2:0], il};
                default: ef = b;
            endcase
        end
        eflg = {v, cy, ef[W-1], (ef == '0)};
    endtask

    initial begin : watchdog
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] ef;
        logic [3:0]   eflg;
        logic [W-1:0] ops [6];
        fs = '0; a_in = '0; b_in = '0; fill_r = 1'b0; fill_l = 1'b0;
        ops = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'hA5};
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state: zero inputs, pass A -> zero result (R1, R8)
        compare("R8 reset", 8'h00, 4'b0001);

        for (int k = 0; k < NV; k++) begin
            apply(VEC[k][33:30], VEC[k][29:22], VEC[k][21:14], VEC[k][13], VEC[k][12]);
            compare(req_of(VEC[k][33:30]), VEC[k][11:4], VEC[k][3:0]);
        end

        // Directed sweep: every code, edge operands, both fills (R1..R8)
        for (int c = 0; c < 16; c++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    for (int f = 0; f < 4; f++) begin
                        apply(4'(c), ops[i], ops[j], f[0], f[1]);
                        model(4'(c), ops[i], ops[j], f[0], f[1], ef, eflg);
                        compare({req_of(4'(c)), "/R8 sweep"}, ef, eflg);
                    end
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule